// File: doc/BRIEF.md
# Incremental Restoring Divider

This block is an unsigned divider that a micro-sequencer drives one operation at a time instead of letting it run an internal loop. A start operation takes the upper word of a double-width dividend together with the divisor. It stores the divisor and divides the upper word at once, leaving a partial quotient and remainder in internal registers. Each later step operation feeds one more bit of the lower dividend word into the remainder and adds one quotient bit by trial subtraction.

The sequencer tracks progress through a count of lower-word bits not yet consumed. A step receives that count and returns it reduced by one. It can also report through the zero flag whether any bits remain. A step that receives a count of zero leaves all state untouched. Two readout operations return the stored quotient or remainder. Results, and any flag write, appear on the registered outputs in the cycle after the operation is issued.

Top module: `seqdiv_unit`

## Requirements
- R1: After reset, res_valid and ezf_we are 0, and the stored quotient and remainder both read back as zero.
- R2: A start operation (op_code 0) stores src_b as the divisor and sets quotient = src_a / src_b and remainder = src_a % src_b. In the following cycle res_valid and ezf_we are both 0.
- R3: A start operation with a zero divisor sets the quotient to all ones and the remainder to src_a.
- R4: A step operation (op_code 1) with count c = src_b in 1..W takes bit c-1 of src_a. It appends that bit below the remainder and subtracts the divisor when the result is not smaller than it. The quotient shifts left by one with the new bit in bit 0. res_data returns c-1.
- R5: A step with a count greater than W consumes a dividend bit of value zero and returns c-1.
- R6: A step with a count of zero changes neither quotient nor remainder, and returns 0 in res_data.
- R7: A step with flag_req set pulses ezf_we and drives ezf_out = 1 exactly when the returned count is zero. No other operation, and no step without flag_req, raises ezf_we.
- R8: A quotient readout (op_code 2) or remainder readout (op_code 3) returns the stored register on res_data with res_valid = 1 and ezf_we = 0.
- R9: All outputs are registered one cycle after the operation. A cycle with op_valid low gives res_valid = 0 and changes no state.
- R10: A start with upper word h and divisor d != 0, followed by W steps with counts W down to 1 on lower word l, leaves remainder = {h,l} % d and quotient = low W bits of {h,l} / d.
- R11: A readout issued in the cycle right after a step returns the value that step produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 2 | 0 start, 1 step, 2 quotient readout, 3 remainder readout |
| src_a | input | W | Start: upper dividend word. Step: lower dividend word |
| src_b | input | W | Start: divisor. Step: remaining bit count |
| flag_req | input | 1 | Step asks for a zero-flag update |
| res_valid | output | 1 | res_data carries a destination value |
| res_data | output | W | Returned count or readout value |
| ezf_we | output | 1 | Zero flag write strobe |
| ezf_out | output | 1 | Zero flag value, 1 when no bits remain |

## Verification
The state update of a step and the readout of that state meet when a readout is issued in the very next cycle. The exhaustive sweep always follows the last step straight away with quotient and remainder readouts and compares them with arithmetic on the full double-width dividend. A step also returns its count in the same cycle that it may write the zero flag. Every sweep step requests the flag, so the returned count and the flag value are judged together, and the flag must be set only on the final step. A zero-count step is checked in the same way: it must still return a count and a set flag while the following readouts show unchanged state.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STEP  = 2'd1,
      OP_RDQ   = 2'd2,
      OP_RDR   = 2'd3
   } seqdiv_op_e;
endpackage

// File: rtl/seqdiv_trial.sv
module seqdiv_trial #(
   parameter int W = 16
) (
   input  logic [W-1:0] rem_in,
   input  logic         bit_in,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] rem_out,
   output logic         q_bit
);
   logic [W:0] trial;
   logic [W:0] ext_div;
   logic [W:0] diff;

   always_comb begin
      trial   = {rem_in, bit_in};
      ext_div = {1'b0, divisor};
      diff    = trial - ext_div;
      q_bit   = (trial >= ext_div);
      rem_out = W'(q_bit ? diff : trial);
   end
endmodule

// File: rtl/seqdiv_array.sv
module seqdiv_array #(
   parameter int W = 16
) (
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   logic [W-1:0] chain [0:W];

   assign chain[0] = '0;

   for (genvar i = 0; i < W; i++) begin : g_stage
      seqdiv_trial #(.W(W)) u_trial (
         .rem_in  (chain[i]),
         .bit_in  (dividend[W-1-i]),
         .divisor (divisor),
         .rem_out (chain[i+1]),
         .q_bit   (quo[W-1-i])
      );
   end

   assign rem = chain[W];
endmodule

// File: rtl/seqdiv_unit.sv
module seqdiv_unit
   import seqdiv_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [1:0]   op_code,
   input  logic [W-1:0] src_a,
   input  logic [W-1:0] src_b,
   input  logic         flag_req,
   output logic         res_valid,
   output logic [W-1:0] res_data,
   output logic         ezf_we,
   output logic         ezf_out
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_bad_width
      $error("seqdiv_unit: W must be at least 2");
   end

   logic [W-1:0] quo_q, rem_q, div_q;
   logic         is_start, is_step, is_rdq, is_rdr;
   logic         cnt_zero, step_go, step_bit, step_qb;
   logic [W-1:0] cnt_m1, next_cnt;
   logic [W-1:0] arr_q, arr_r, step_r;

   always_comb begin
      is_start = op_valid && (op_code == OP_START);
      is_step  = op_valid && (op_code == OP_STEP);
      is_rdq   = op_valid && (op_code == OP_RDQ);
      is_rdr   = op_valid && (op_code == OP_RDR);
      cnt_zero = (src_b == '0);
      cnt_m1   = src_b - ONE;
      next_cnt = cnt_zero ? '0 : cnt_m1;
      step_go  = is_step && !cnt_zero;
      step_bit = |(src_a & (ONE << cnt_m1));
   end

   seqdiv_array #(.W(W)) u_first (
      .dividend (src_a),
      .divisor  (src_b),
      .quo      (arr_q),
      .rem      (arr_r)
   );

   seqdiv_trial #(.W(W)) u_step (
      .rem_in  (rem_q),
      .bit_in  (step_bit),
      .divisor (div_q),
      .rem_out (step_r),
      .q_bit   (step_qb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo_q <= '0;
         rem_q <= '0;
         div_q <= '0;
      end else if (is_start) begin
         div_q <= src_b;
         quo_q <= arr_q;
         rem_q <= arr_r;
      end else if (step_go) begin
         rem_q <= step_r;
         quo_q <= {quo_q[W-2:0], step_qb};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         ezf_we    <= 1'b0;
         ezf_out   <= 1'b0;
      end else begin
         res_valid <= is_step || is_rdq || is_rdr;
         if (is_step)     res_data <= next_cnt;
         else if (is_rdq) res_data <= quo_q;
         else if (is_rdr) res_data <= rem_q;
         else             res_data <= '0;
         ezf_we <= is_step && flag_req;
         if (is_step && flag_req) ezf_out <= (next_cnt == '0);
      end
   end
endmodule

// File: rtl/seqdiv_unit_chk.sv
module seqdiv_unit_chk
   import seqdiv_pkg::*;
#(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [1:0]   op_code,
   input logic [W-1:0] src_b,
   input logic         flag_req,
   input logic         res_valid,
   input logic [W-1:0] res_data,
   input logic         ezf_we,
   input logic [W-1:0] quo_q,
   input logic [W-1:0] rem_q,
   input logic [W-1:0] div_q
);
   // R2: start returns nothing and writes no flag
   a_r2_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_START) |=> (!res_valid && !ezf_we));

   // R2: remainder left by a start is below a nonzero divisor
   a_r2_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_START && src_b != '0) |=> (rem_q < div_q));

   // R4: step returns the count minus one
   a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_STEP && src_b != '0)
      |=> (res_valid && res_data == $past(src_b) - W'(1)));

   // R6: zero count holds state
   a_r6_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_STEP && src_b == '0)
      |=> ($stable(quo_q) && $stable(rem_q) && res_data == '0));

   // R7: only a flag-requesting step writes the flag
   a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_code == OP_STEP && flag_req) |=> !ezf_we);

   // R8: readouts return a value and write no flag
   a_r8_readout: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code[1]) |=> (res_valid && !ezf_we));

   // R9: idle cycle returns nothing and keeps state
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && $stable(quo_q) && $stable(rem_q) && $stable(div_q)));
endmodule

bind seqdiv_unit seqdiv_unit_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .src_b     (src_b),
   .flag_req  (flag_req),
   .res_valid (res_valid),
   .res_data  (res_data),
   .ezf_we    (ezf_we),
   .quo_q     (quo_q),
   .rem_q     (rem_q),
   .div_q     (div_q)
);

// File: tb/sim_seqdiv_unit.sv
`timescale 1ns/1ps
module sim_seqdiv_unit;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [1:0]   op_code = 2'd0;
   logic [W-1:0] src_a = '0;
   logic [W-1:0] src_b = '0;
   logic         flag_req = 1'b0;
   logic         res_valid;
   logic [W-1:0] res_data;
   logic         ezf_we;
   logic         ezf_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic         o_valid;
   logic [W-1:0] o_data;
   logic         o_we;
   logic         o_ezf;

   always #2 clk = ~clk;

   seqdiv_unit #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .src_a(src_a), .src_b(src_b), .flag_req(flag_req),
      .res_valid(res_valid), .res_data(res_data),
      .ezf_we(ezf_we), .ezf_out(ezf_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic issue(input logic v, input logic [1:0] code,
                        input int a, input int b, input logic fr);
      @(negedge clk);
      op_valid = v;
      op_code  = code;
      src_a    = W'(a);
      src_b    = W'(b);
      flag_req = fr;
      @(posedge clk);
      #1;
      o_valid  = res_valid;
      o_data   = res_data;
      o_we     = ezf_we;
      o_ezf    = ezf_out;
      op_valid = 1'b0;
   endtask

   task automatic read_both(input string req, input int eq, input int er);
      issue(1'b1, 2'd2, 0, 0, 1'b0);
      check({req, " quotient"}, int'(o_data), eq);
      check({req, " quotient no flag (R8)"}, int'(o_we), 0);
      issue(1'b1, 2'd3, 0, 0, 1'b0);
      check({req, " remainder"}, int'(o_data), er);
      check({req, " readout valid (R8)"}, int'(o_valid), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 res_valid at reset", int'(res_valid), 0);
      check("R1 ezf_we at reset", int'(ezf_we), 0);
      @(negedge clk);
      rst_n = 1'b1;
      read_both("R1 reset state", 0, 0);

      // R3: zero divisor
      issue(1'b1, 2'd0, 8'hA5, 0, 1'b0);
      read_both("R3 zero divisor", 255, 8'hA5);

      // R5: count above W consumes a zero bit
      issue(1'b1, 2'd0, 3, 7, 1'b0);
      issue(1'b1, 2'd1, 8'hFF, 9, 1'b0);
      check("R5 returned count", int'(o_data), 8);
      read_both("R5 zero bit consumed", 0, 6);

      // R4: same state, count 1 consumes bit 0 (a one)
      issue(1'b1, 2'd0, 3, 7, 1'b0);
      issue(1'b1, 2'd1, 8'hFF, 1, 1'b0);
      check("R4 returned count", int'(o_data), 0);
      check("R7 no flag without request", int'(o_we), 0);
      read_both("R4 single step", 1, 0);

      // R6: zero count holds state and still reports the flag
      issue(1'b1, 2'd0, 5, 9, 1'b0);
      issue(1'b1, 2'd1, 8'hFF, 0, 1'b1);
      check("R6 returned count", int'(o_data), 0);
      check("R6 flag write", int'(o_we), 1);
      check("R7 flag set on zero count", int'(o_ezf), 1);
      read_both("R6 state held", 0, 5);

      // R9: idle cycle with start-like inputs
      issue(1'b0, 2'd0, 8'h11, 3, 1'b1);
      check("R9 idle no result", int'(o_valid), 0);
      check("R9 idle no flag", int'(o_we), 0);
      read_both("R9 idle state held", 0, 5);

      // R10/R11: sweep of divisors and dividends
      for (int d = 1; d < 256; d++) begin
         for (int k = 0; k < 4; k++) begin
            int hi, lo, dv;
            case (k)
               0: hi = 0;
               1: hi = d - 1;
               2: hi = 255;
               default: hi = (d * 37) % 256;
            endcase
            lo = (d * 53 + hi * 7 + k) % 256;
            dv = hi * 256 + lo;
            issue(1'b1, 2'd0, hi, d, 1'b0);
            check("R2 start no result", int'(o_valid), 0);
            check("R2 start no flag", int'(o_we), 0);
            read_both("R2 start", hi / d, hi % d);
            for (int c = W; c >= 1; c--) begin
               issue(1'b1, 2'd1, lo, c, 1'b1);
               check("R4 step count", int'(o_data), c - 1);
               check("R7 step flag write", int'(o_we), 1);
               check("R7 step flag value", int'(o_ezf), (c == 1) ? 1 : 0);
            end
            read_both("R10 R11 full division", (dv / d) % 256, dv % d);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule